// File: doc/BRIEF.md
# EEPROM Page-Write Controller

This block is a clocked behavioural model of the write side of a byte-wide, page-programmed EEPROM. A host drives active-low chip select, write enable and output enable, an address bus and a data bus. A host write is the window in which chip select and write enable are both low and output enable is high. Each qualified write is taken as one byte load into a page buffer. A retriggerable load timer measures the quiet time after the most recent load. When that timer runs out, the block enters a programming phase of fixed length. At its end, every loaded byte of the page is committed to the internal array in one step.

During programming a busy output is high. A read of the most recently loaded address returns the loaded byte with its most significant bit inverted, so software can poll for completion. All delays are parameters counted in clock cycles: the minimum strobe width, the load timeout and the programming time. Simulations can therefore use short values. The address is split into a page tag in the upper bits and a byte offset in the lowest `PAGE_BITS` bits.

Top module: `eeprom_page_writer`

## Requirements
- R1: A byte load is taken from a write window (cs_n=0, we_n=0, oe_n=1) that lasts at least MIN_PULSE clock edges. The address is sampled on the first clock edge of the window, and the data on the first edge after the window closes.
- R2: A write window that lasts fewer than MIN_PULSE clock edges loads nothing, starts no timer and changes no array byte.
- R3: While oe_n is low no write window exists. If oe_n falls while a window is open, that window is discarded.
- R4: Every accepted load restarts the load timer. If no further load is accepted, programming starts LOAD_TIMEOUT edges after the edge on which the last load was taken in. A load that arrives on the edge where the timer expires wins, and is added to the page.
- R5: busy is high for exactly PROG_CYCLES clock edges. All loaded bytes of the page are written to the array together on the edge where busy falls, and array bytes read before that edge keep their old values.
- R6: While busy is high, a read of the last loaded address returns that byte with bit 7 inverted and bits 6..0 unchanged. After busy falls, the same read returns the true byte.
- R7: A load whose page tag (address bits above the low PAGE_BITS) differs from the tag of the page being gathered is discarded. It sets proto_err, which stays high until that page's programming ends.
- R8: A write window that closes while busy is high is ignored, and it does not start a new page after programming.
- R9: dout shows the array byte at addr while cs_n and oe_n are both low, and is 0 otherwise.
- R10: After reset, busy and proto_err are 0 and every array byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; low PAGE_BITS bits are the page offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| busy | output | 1 | High during the programming phase |
| proto_err | output | 1 | A load with a foreign page tag was discarded |

## Verification
Two events can land on the same clock edge: the acceptance of a byte load and the expiry of the load timer. A load is taken in on the edge after its window closes. The bench therefore spaces two loads so that the second window closes exactly LOAD_TIMEOUT edges after the first. That second load reaches the controller on the very edge the timer expires. The load must win: the byte is committed with the page and busy stays low for one more timeout. A second pairing shifts the next window one edge later, so it arrives on the first programming edge. That byte must be dropped, and the array and busy output are read afterwards to confirm it.

// File: rtl/eep_pkg.sv
// Shared types for the EEPROM page-write controller.
package eep_pkg;

    // Controller phases: idle, gathering a page, programming the page.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_e;

endpackage

// File: rtl/eep_strobe_filter.sv
// Turns the raw chip-select / write-enable / output-enable pins into
// qualified byte-load pulses. A write window is the overlap of cs_n and
// we_n low with oe_n high. The address is latched on the first edge of the
// window and the data on the first edge after it closes. Windows shorter
// than MIN_PULSE edges, or ended by oe_n falling, produce nothing.
// Assumes pins are already synchronous to clk.
module eep_strobe_filter #(
    parameter int ADDR_W    = 8,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              load_vld,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic              win;
    logic              win_q;
    logic [CW-1:0]     wcnt;
    logic [ADDR_W-1:0] addr_lat;

    assign win = ~cs_n & ~we_n & oe_n;

    // Track window width, latch address at open, emit a load at close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= 1'b0;
            wcnt      <= '0;
            addr_lat  <= '0;
            load_vld  <= 1'b0;
            load_addr <= '0;
            load_data <= '0;
        end else begin
            win_q    <= win;
            load_vld <= 1'b0;
            if (win && !win_q) begin
                addr_lat <= addr;
                wcnt     <= CW'(1);
            end else if (win && wcnt != CW'(MIN_PULSE)) begin
                wcnt <= wcnt + CW'(1);
            end
            if (!win && win_q) begin
                if (oe_n && wcnt == CW'(MIN_PULSE)) begin
                    load_vld <= 1'b1;
                end
                load_addr <= addr_lat;
                load_data <= din;
            end
        end
    end

endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: one byte slot and one valid flag per offset in a page.
// Slots are written by accepted loads and all flags clear on commit.
module eep_page_buf #(
    parameter int PAGE_BITS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [PAGE_BITS-1:0]          wr_off,
    input  logic [7:0]                    wr_data,
    input  logic                          clr,
    output logic [(1<<PAGE_BITS)-1:0][7:0] slot_data,
    output logic [(1<<PAGE_BITS)-1:0]     slot_vld
);
    localparam int PAGE = 1 << PAGE_BITS;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        // Capture one byte for this offset; drop its flag on commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[g] <= '0;
                slot_vld[g]  <= 1'b0;
            end else if (clr) begin
                slot_vld[g] <= 1'b0;
            end else if (wr_en && wr_off == PAGE_BITS'(g)) begin
                slot_data[g] <= wr_data;
                slot_vld[g]  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/eep_seq.sv
// Phase sequencer: gathers loads of one page under a retriggerable
// timeout, then runs a fixed programming phase and issues a one-cycle
// commit on its last edge. It also keeps the last load for polling reads
// and flags loads with a foreign page tag. Loads during programming are
// dropped.
module eep_seq
    import eep_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BITS    = 4,
    parameter int LOAD_TIMEOUT = 20,
    parameter int PROG_CYCLES  = 40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_vld,
    input  logic [ADDR_W-1:0]           load_addr,
    input  logic [7:0]                  load_data,
    output logic                        accept,
    output logic                        commit,
    output logic                        busy,
    output logic                        proto_err,
    output logic [ADDR_W-PAGE_BITS-1:0] page_tag,
    output logic [ADDR_W-1:0]           last_addr,
    output logic [7:0]                  last_data
);
    localparam int TAG_W = ADDR_W - PAGE_BITS;
    localparam int TW    = $clog2(LOAD_TIMEOUT + 1);
    localparam int PW    = $clog2(PROG_CYCLES + 1);

    eep_state_e       state;
    logic [TW-1:0]    tmr;
    logic [PW-1:0]    pcnt;
    logic [TAG_W-1:0] tag_in;
    logic             mismatch;

    assign tag_in   = load_addr[ADDR_W-1:PAGE_BITS];
    assign accept   = load_vld && ((state == ST_IDLE) ||
                      (state == ST_LOAD && tag_in == page_tag));
    assign mismatch = load_vld && state == ST_LOAD && tag_in != page_tag;
    assign commit   = (state == ST_PROG) && (pcnt == PW'(PROG_CYCLES - 1));
    assign busy     = (state == ST_PROG);

    // Phase transitions, load timer and programming counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tmr      <= '0;
            pcnt     <= '0;
            page_tag <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_LOAD;
                        tmr      <= '0;
                        page_tag <= tag_in;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        tmr <= '0;
                    end else if (tmr == TW'(LOAD_TIMEOUT - 1)) begin
                        state <= ST_PROG;
                        pcnt  <= '0;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        state <= ST_IDLE;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky tag-mismatch flag, cleared when the page is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else if (mismatch) begin
            proto_err <= 1'b1;
        end else if (commit) begin
            proto_err <= 1'b0;
        end
    end

    // Remember the most recent accepted load for polling reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (accept) begin
            last_addr <= load_addr;
            last_data <= load_data;
        end
    end

endmodule

// File: rtl/eeprom_page_writer.sv
// Top level of the page-write EEPROM model: strobe filter, sequencer, page
// buffer and a register array with a combinational read port. Reads during
// programming of the last loaded address return the polling pattern.
module eeprom_page_writer #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BITS    = 4,
    parameter int LOAD_TIMEOUT = 20,
    parameter int PROG_CYCLES  = 40,
    parameter int MIN_PULSE    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              proto_err
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_BITS;
    localparam int TAG_W = ADDR_W - PAGE_BITS;

    logic              load_vld;
    logic [ADDR_W-1:0] load_addr;
    logic [7:0]        load_data;
    logic              accept;
    logic              commit;
    logic [TAG_W-1:0]  page_tag;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        last_data;
    logic [PAGE-1:0][7:0] slot_data;
    logic [PAGE-1:0]   slot_vld;
    logic [7:0]        mem [DEPTH];

    eep_strobe_filter #(
        .ADDR_W   (ADDR_W),
        .MIN_PULSE(MIN_PULSE)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .load_vld (load_vld),
        .load_addr(load_addr),
        .load_data(load_data)
    );

    eep_seq #(
        .ADDR_W      (ADDR_W),
        .PAGE_BITS   (PAGE_BITS),
        .LOAD_TIMEOUT(LOAD_TIMEOUT),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_vld (load_vld),
        .load_addr(load_addr),
        .load_data(load_data),
        .accept   (accept),
        .commit   (commit),
        .busy     (busy),
        .proto_err(proto_err),
        .page_tag (page_tag),
        .last_addr(last_addr),
        .last_data(last_data)
    );

    eep_page_buf #(
        .PAGE_BITS(PAGE_BITS)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_off   (load_addr[PAGE_BITS-1:0]),
        .wr_data  (load_data),
        .clr      (commit),
        .slot_data(slot_data),
        .slot_vld (slot_vld)
    );

    // Array: clear on reset, write every loaded slot of the page at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                mem[j] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (slot_vld[i]) begin
                    mem[{page_tag, PAGE_BITS'(i)}] <= slot_data[i];
                end
            end
        end
    end

    // Read port with polling override for the last loaded address.
    always_comb begin
        if (cs_n || oe_n) begin
            dout = '0;
        end else if (busy && addr == last_addr) begin
            dout = {~last_data[7], last_data[6:0]};
        end else begin
            dout = mem[addr];
        end
    end

endmodule

// File: rtl/eep_checker.sv
// Temporal checks on the page-write controller, bound into the top level.
// Keeps its own counters of busy length and write-window width.
module eep_checker #(
    parameter int PROG_CYCLES = 40,
    parameter int MIN_PULSE   = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic busy,
    input logic proto_err,
    input logic load_vld
);
    localparam int BW = $clog2(PROG_CYCLES + 2);
    localparam int OW = $clog2(MIN_PULSE + 2);

    logic [BW-1:0] brun;
    logic [OW-1:0] orun;

    // Count consecutive busy edges, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brun <= '0;
        end else if (!busy) begin
            brun <= '0;
        end else if (brun != BW'(PROG_CYCLES + 1)) begin
            brun <= brun + BW'(1);
        end
    end

    // Count consecutive edges of an open write window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orun <= '0;
        end else if (cs_n || we_n || !oe_n) begin
            orun <= '0;
        end else if (orun != OW'(MIN_PULSE + 1)) begin
            orun <= orun + OW'(1);
        end
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        brun <= BW'(PROG_CYCLES)); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> brun == BW'(PROG_CYCLES)); // R5
    AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |-> $past(orun) >= OW'(MIN_PULSE)); // R2
    AST_LOAD_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |-> $past(oe_n)); // R3
    AST_ERR_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(load_vld)); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !proto_err); // R7
    AST_LOAD_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(load_vld)); // R4

endmodule

bind eeprom_page_writer eep_checker #(
    .PROG_CYCLES(PROG_CYCLES),
    .MIN_PULSE  (MIN_PULSE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .busy     (busy),
    .proto_err(proto_err),
    .load_vld (load_vld)
);

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb;
    localparam int AW   = 8;
    localparam int LTO  = 20;
    localparam int PROG = 40;
    localparam int MINW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          busy;
    logic          proto_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(AW), .PAGE_BITS(4), .LOAD_TIMEOUT(LTO),
        .PROG_CYCLES(PROG), .MIN_PULSE(MINW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy),
        .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Read inside the current low clock phase; no clock edge is spent.
    task automatic rd_now(input logic [7:0] a, output logic [7:0] d);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        #0.5;
        d = dout;
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd_now(a, d);
        chk(tag, int'(d), int'(exp));
    endtask

    // Byte write: gap idle negedges, then a window of width edges.
    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d,
                           input int width, input int gap);
        repeat (gap) @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; we_n = 1'b0;
        repeat (width) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic settle();
        repeat (LTO + PROG + 10) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 proto_err after reset", int'(proto_err), 0);
        rd_chk("R10 mem[00] after reset", 8'h00, 8'h00);
        rd_chk("R10 mem[ff] after reset", 8'hff, 8'h00);
    endtask

    task automatic t_single();
        wr_byte(8'h12, 8'hA5, MINW, 1);
        repeat (LTO + 1) @(negedge clk);
        chk("R4 busy low before timeout", int'(busy), 0);
        @(negedge clk);
        chk("R4 busy high at timeout", int'(busy), 1);
        rd_chk("R6 poll inverts bit 7", 8'h12, 8'h25);
        rd_chk("R5 other address unchanged", 8'h13, 8'h00);
        repeat (PROG - 1) @(negedge clk);
        chk("R5 busy still high at last cycle", int'(busy), 1);
        rd_chk("R6 poll before commit", 8'h12, 8'h25);
        @(negedge clk);
        chk("R5 busy low after PROG cycles", int'(busy), 0);
        rd_chk("R6 true data after commit", 8'h12, 8'hA5);
    endtask

    task automatic t_page();
        logic [7:0] pd [4] = '{8'h11, 8'h9A, 8'h5E, 8'h3C};
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'h40 + 8'(i), pd[i], 4, (i == 0) ? 1 : 10);
            if (i < 3) chk("R4 retrigger keeps busy low", int'(busy), 0);
        end
        repeat (LTO + 2) @(negedge clk);
        chk("R4 busy after page timeout", int'(busy), 1);
        rd_chk("R5 page byte old during prog", 8'h40, 8'h00);
        rd_chk("R6 poll last page byte", 8'h43, 8'hBC);
        repeat (PROG + 2) @(negedge clk);
        for (int i = 0; i < 4; i++) rd_chk("R5 page committed", 8'h40 + 8'(i), pd[i]);
        rd_chk("R5 unloaded slot untouched", 8'h44, 8'h00);
    endtask

    task automatic t_glitch();
        wr_byte(8'h60, 8'h77, MINW - 1, 1);
        repeat (LTO + 5) @(negedge clk);
        chk("R2 short window starts nothing", int'(busy), 0);
        rd_chk("R2 short window no write", 8'h60, 8'h00);
        wr_byte(8'h60, 8'h77, MINW, 1);
        settle();
        rd_chk("R1 minimum width accepted", 8'h60, 8'h77);
    endtask

    task automatic t_oe();
        @(negedge clk);
        addr = 8'h61; din = 8'h99; oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
        addr = 8'h62; din = 8'h55; cs_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (LTO + 5) @(negedge clk);
        chk("R3 oe low no load", int'(busy), 0);
        rd_chk("R3 oe held low no write", 8'h61, 8'h00);
        rd_chk("R3 oe fall aborts window", 8'h62, 8'h00);
    endtask

    task automatic t_mismatch();
        wr_byte(8'h03, 8'h5A, MINW, 1);
        wr_byte(8'h04, 8'h6B, MINW, 5);
        chk("R7 no error on same page", int'(proto_err), 0);
        wr_byte(8'h25, 8'hC3, MINW, 5);
        repeat (2) @(negedge clk);
        chk("R7 foreign tag flagged", int'(proto_err), 1);
        settle();
        chk("R7 flag cleared after commit", int'(proto_err), 0);
        rd_chk("R7 foreign byte dropped", 8'h25, 8'h00);
        rd_chk("R7 page byte 0 kept", 8'h03, 8'h5A);
        rd_chk("R7 page byte 1 kept", 8'h04, 8'h6B);
    endtask

    task automatic t_tie_late();
        wr_byte(8'h80, 8'h21, MINW, 1);
        wr_byte(8'h81, 8'h43, MINW, LTO - MINW);
        chk("R4 tie load keeps busy low", int'(busy), 0);
        wr_byte(8'h82, 8'h65, MINW, LTO - MINW + 1);
        repeat (2) @(negedge clk);
        chk("R8 late load during prog", int'(busy), 1);
        repeat (PROG + 2) @(negedge clk);
        rd_chk("R4 first byte committed", 8'h80, 8'h21);
        rd_chk("R4 tie byte committed", 8'h81, 8'h43);
        rd_chk("R8 byte during prog dropped", 8'h82, 8'h00);
        repeat (LTO + 5) @(negedge clk);
        chk("R8 no new page after prog", int'(busy), 0);
    endtask

    task automatic t_latch();
        @(negedge clk);
        addr = 8'h90; din = 8'h01; cs_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 8'h91; din = 8'hE7;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        settle();
        rd_chk("R1 address from window start", 8'h90, 8'hE7);
        rd_chk("R1 later address not written", 8'h91, 8'h00);
    endtask

    task automatic t_read_gate();
        @(negedge clk);
        addr = 8'h12; cs_n = 1'b0; oe_n = 1'b1;
        #0.5;
        chk("R9 dout zero with oe_n high", int'(dout), 0);
        cs_n = 1'b1; oe_n = 1'b0;
        #0.5;
        chk("R9 dout zero with cs_n high", int'(dout), 0);
        oe_n = 1'b1;
        rd_chk("R9 dout shows array byte", 8'h12, 8'hA5);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_page();
        t_glitch();
        t_oe();
        t_mismatch();
        t_tie_late();
        t_latch();
        t_read_gate();
        finish_run();
    end

endmodule